// File: doc/BRIEF.md
# Two-to-One Clock-Ratio Width Downconverter

This block turns a stream of 64-bit words, one on every rising edge of a slow clock, into a stream of 32-bit words on a fast clock. The fast clock is phase-locked to the slow one and runs at exactly twice its rate, so every fast rising edge that falls on a slow rising edge is simultaneous with it. The incoming words land in a small ring of 64-bit registers. A write pointer in the slow domain addresses the ring. A copy of that pointer is registered on the fast clock and is used only to decide when streaming starts and to detect a pointer collision. The read side walks the ring at its own fixed pace, two fast cycles per entry: lower half first, then upper half.

No empty flag and no generic FIFO logic are involved. The output rate equals the input rate by construction of the clock ratio. The read pointer starts half a ring behind the write pointer and stays there, so each accepted word comes out exactly twice as 32-bit halves, in order, with no repeats and no gaps. A sticky flag reports any case where the read pointer meets the registered write pointer. That can only happen when the clock relationship is broken.

Top module: `wdc_top`

## Requirements
- R1: On every slow rising edge with reset low, the 64-bit input is stored in the ring entry addressed by the write pointer. The pointer then steps by one and wraps after DEPTH entries. DEPTH is a power of two, at least 4, and defaults to 4.
- R2: The write pointer is registered on the fast clock. Streaming begins once DEPTH/2 pointer steps have been counted there. Take the fast edge that coincides with the slow edge capturing the first word after reset as edge 0. The first valid output appears right after fast edge DEPTH+1, which is edge 5 at the default depth.
- R3: Each stored word is emitted on two consecutive fast cycles: bits [31:0] first, then bits [63:32]. The read pointer advances only after the upper half has been issued.
- R4: Once out_valid has risen, it stays high on every fast cycle until reset. The valid outputs are exactly the halves of the accepted words, in arrival order, with none repeated and none dropped.
- R5: out_valid and out_data are registered. They change one fast edge after the read decision, and out_valid stays low before streaming begins.
- R6: A synchronous active-high reset clears both pointers, the half select, the start counter and collide_err. It drops out_valid at the next fast edge. After reset is released, the latency of R2 applies again.
- R7: collide_err is set and held when, during streaming, the fast-domain copy of the write pointer equals the read pointer. Only reset clears it. It stays low while both clocks run in their locked 2:1 relation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Slow clock, input word rate |
| clk_f | input | 1 | Fast clock, twice clk_s, phase-locked |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| in_data | input | 64 | Input word, captured on every slow rising edge |
| out_data | output | 32 | Output half-word |
| out_valid | output | 1 | out_data carries a valid half-word |
| collide_err | output | 1 | Sticky pointer-collision flag |

## Verification
All timing is counted in fast edges from the fast edge that coincides with the slow edge capturing the first word. At the default depth, the lower half of word k is due right after fast edge 2k+5 and the upper half right after edge 2k+6. out_valid must be low right after the first fast edge that sees reset high. The bench keeps a queue of expected halves that it fills on each slow capture. It samples the outputs 1 ns after every fast edge, where every register on the path has settled, and compares them with the head of the queue once the counted edge index reaches the start point. collide_err is provoked by holding the slow clock for two of its periods. It is checked only after several further fast edges, and is then checked again for stickiness and for clearing by reset.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    localparam int DEF_OUT_W = 32;
    localparam int DEF_DEPTH = 4;

    // which half of a stored word is being issued
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    // read request passed from the pointer logic to the output stage
    typedef struct packed {
        logic  vld;
        half_e half;
    } rd_req_t;

    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic half_e flip_half(input half_e h);
        return (h == HALF_LO) ? HALF_HI : HALF_LO;
    endfunction

endpackage

// File: rtl/wdc_ring.sv
module wdc_ring #(
    parameter int DEPTH = 4,
    parameter int IN_W  = 64,
    parameter int PW    = 2
) (
    input  logic            clk_s,
    input  logic            rst,
    input  logic [IN_W-1:0] in_data,
    input  logic [PW-1:0]   rd_ptr,
    output logic [PW-1:0]   wr_ptr,
    output logic [IN_W-1:0] rd_word
);

    logic [IN_W-1:0] mem [DEPTH];

    // slow domain: pointer steps once per slow cycle
    always_ff @(posedge clk_s) begin
        if (rst) begin
            wr_ptr <= '0;
        end else begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // storage is not reset; the read side never touches an entry before it is filled
    always_ff @(posedge clk_s) begin
        if (!rst) begin
            mem[wr_ptr] <= in_data;
        end
    end

    // read port used from the fast domain; entry is stable for several fast edges
    assign rd_word = mem[rd_ptr];

endmodule

// File: rtl/wdc_rd_ctrl.sv
module wdc_rd_ctrl
    import wdc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PW    = 2
) (
    input  logic          clk_f,
    input  logic          rst,
    input  logic [PW-1:0] wr_ptr_s,
    output logic [PW-1:0] rd_ptr,
    output rd_req_t       rd_req,
    output logic          collide_err
);

    localparam int HALF = DEPTH / 2;
    localparam int CW   = $clog2(HALF + 1);

    logic [PW-1:0] wp_f;
    logic [PW-1:0] wp_prev;
    logic [CW-1:0] wcnt;
    logic          streaming;
    half_e         half_q;
    logic          step_seen;

    // a change of the registered pointer marks one completed slow write
    assign step_seen = (wp_f != wp_prev);

    always_ff @(posedge clk_f) begin
        if (rst) begin
            wp_f        <= '0;
            wp_prev     <= '0;
            wcnt        <= '0;
            streaming   <= 1'b0;
            half_q      <= HALF_LO;
            rd_ptr      <= '0;
            collide_err <= 1'b0;
        end else begin
            wp_f    <= wr_ptr_s;
            wp_prev <= wp_f;

            if (!streaming && step_seen) begin
                wcnt <= wcnt + 1'b1;
                if (wcnt == CW'(HALF - 1)) begin
                    streaming <= 1'b1;
                end
            end

            if (streaming) begin
                half_q <= flip_half(half_q);
                if (half_q == HALF_HI) begin
                    rd_ptr <= rd_ptr + 1'b1;
                end
                if (wp_f == rd_ptr) begin
                    collide_err <= 1'b1;
                end
            end
        end
    end

    assign rd_req.vld  = streaming;
    assign rd_req.half = half_q;

endmodule

// File: rtl/wdc_out_mux.sv
module wdc_out_mux
    import wdc_pkg::*;
#(
    parameter int OUT_W = 32,
    parameter int IN_W  = 64
) (
    input  logic             clk_f,
    input  logic             rst,
    input  rd_req_t          rd_req,
    input  logic [IN_W-1:0]  rd_word,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid
);

    logic [OUT_W-1:0] sel_half;

    assign sel_half = (rd_req.half == HALF_HI) ? rd_word[IN_W-1:OUT_W]
                                               : rd_word[OUT_W-1:0];

    // one register stage covers the read latency
    always_ff @(posedge clk_f) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= rd_req.vld;
            if (rd_req.vld) begin
                out_data <= sel_half;
            end
        end
    end

endmodule

// File: rtl/wdc_top.sv
module wdc_top
    import wdc_pkg::*;
#(
    parameter int OUT_W = DEF_OUT_W,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic               clk_s,
    input  logic               clk_f,
    input  logic               rst,
    input  logic [2*OUT_W-1:0] in_data,
    output logic [OUT_W-1:0]   out_data,
    output logic               out_valid,
    output logic               collide_err
);

    localparam int IN_W = 2 * OUT_W;
    localparam int PW   = ptr_bits(DEPTH);

    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [IN_W-1:0] rd_word;
    rd_req_t         rd_req;
    logic            half_sel;

    wdc_ring #(
        .DEPTH (DEPTH),
        .IN_W  (IN_W),
        .PW    (PW)
    ) u_ring (
        .clk_s   (clk_s),
        .rst     (rst),
        .in_data (in_data),
        .rd_ptr  (rd_ptr),
        .wr_ptr  (wr_ptr),
        .rd_word (rd_word)
    );

    wdc_rd_ctrl #(
        .DEPTH (DEPTH),
        .PW    (PW)
    ) u_ctrl (
        .clk_f       (clk_f),
        .rst         (rst),
        .wr_ptr_s    (wr_ptr),
        .rd_ptr      (rd_ptr),
        .rd_req      (rd_req),
        .collide_err (collide_err)
    );

    wdc_out_mux #(
        .OUT_W (OUT_W),
        .IN_W  (IN_W)
    ) u_mux (
        .clk_f     (clk_f),
        .rst       (rst),
        .rd_req    (rd_req),
        .rd_word   (rd_word),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    assign half_sel = rd_req.half;

endmodule

// File: rtl/wdc_chk.sv
module wdc_chk #(
    parameter int PW = 2
) (
    input logic          clk_s,
    input logic          clk_f,
    input logic          rst,
    input logic          out_valid,
    input logic          collide_err,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic          half_sel
);

    // R1: write pointer steps by one per slow cycle
    p_wr_step_r1: assert property (@(posedge clk_s) disable iff (rst)
        !rst |=> (wr_ptr == PW'($past(wr_ptr) + 1'b1)));

    // R3: read pointer only moves after the upper half was issued
    p_ptr_after_hi_r3: assert property (@(posedge clk_f) disable iff (rst)
        (rd_ptr != $past(rd_ptr)) |-> ($past(half_sel) == 1'b1));

    // R4: streaming never pauses once started
    p_valid_hold_r4: assert property (@(posedge clk_f) disable iff (rst)
        out_valid |=> out_valid);

    // R6: outputs cleared one fast edge after reset
    p_clear_after_reset_r6: assert property (@(posedge clk_f) disable iff (rst)
        $past(rst) |-> (!out_valid && !collide_err));

    // R7: collision flag is sticky
    p_err_sticky_r7: assert property (@(posedge clk_f) disable iff (rst)
        collide_err |=> collide_err);

endmodule

bind wdc_top wdc_chk #(.PW(PW)) u_chk (
    .clk_s       (clk_s),
    .clk_f       (clk_f),
    .rst         (rst),
    .out_valid   (out_valid),
    .collide_err (collide_err),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .half_sel    (half_sel)
);

// File: tb/sim_wdc_top.sv
`timescale 1ns/1ps
module sim_wdc_top;

    localparam int DEPTH = 4;
    localparam int HALF  = DEPTH / 2;

    logic        clk_s = 1'b0;
    logic        clk_f = 1'b0;
    logic        rst   = 1'b1;
    logic        hold  = 1'b0;
    logic        chk_en = 1'b1;
    logic [63:0] in_data = '0;
    logic [31:0] out_data;
    logic        out_valid;
    logic        collide_err;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q [$];
    int words = 0;
    int fcnt  = 0;

    wdc_top #(.OUT_W(32), .DEPTH(DEPTH)) u0 (
        .clk_s       (clk_s),
        .clk_f       (clk_f),
        .rst         (rst),
        .in_data     (in_data),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .collide_err (collide_err)
    );

    // 200 MHz fast clock, slow clock derived at half rate
    always #2.5 clk_f = ~clk_f;
    always @(posedge clk_f) if (!hold) clk_s <= ~clk_s;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] gen(input int k, input int pat);
        case (pat)
            0:       return {32'hA500_0000 + 32'(k), 32'h0000_1000 + 32'(k)};
            1:       return 64'h1 << (k % 64);
            2:       return (k % 2 == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;
            default: return {~32'(k), 32'(k * 3) ^ 32'h5A5A_0F0F};
        endcase
    endfunction

    // model: each accepted word queues its lower then upper half (R1, R3)
    always @(posedge clk_s) begin
        if (!rst && chk_en) begin
            exp_q.push_back(in_data[31:0]);
            exp_q.push_back(in_data[63:32]);
            words++;
        end
    end

    // model: compare 1 ns after each fast edge
    always @(posedge clk_f) begin
        #1;
        if (chk_en) begin
            if (rst) begin
                exp_q.delete();
                words = 0;
                fcnt  = 0;
                chk(out_valid == 1'b0, "R6 valid low in reset", 64'(out_valid), 64'd0);
            end else begin
                if (words > 0) fcnt++;
                if (fcnt >= 2 * HALF + 2) begin
                    logic [31:0] e;
                    chk(out_valid == 1'b1, "R2 R4 valid while streaming", 64'(out_valid), 64'd1);
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_DEAD;
                    chk(out_data == e, "R3 R4 half-word order", 64'(out_data), 64'(e));
                end else begin
                    chk(out_valid == 1'b0, "R2 R5 no valid before start", 64'(out_valid), 64'd0);
                end
                chk(collide_err == 1'b0, "R7 no collision at 2:1", 64'(collide_err), 64'd0);
            end
        end
    end

    task automatic stream(input int n, input int pat);
        @(posedge clk_s);
        @(negedge clk_f);
        rst = 1'b0;
        in_data = gen(0, pat);
        for (int k = 1; k < n; k++) begin
            @(posedge clk_s);
            @(negedge clk_f);
            in_data = gen(k, pat);
        end
        repeat (6) @(posedge clk_s);
    endtask

    task automatic do_reset();
        @(negedge clk_f);
        rst = 1'b1;
        chk_en = 1'b1;
        repeat (3) @(posedge clk_s);
        @(negedge clk_f);
        chk(out_valid == 1'b0, "R6 valid dropped", 64'(out_valid), 64'd0);
        chk(collide_err == 1'b0, "R6 R7 error cleared", 64'(collide_err), 64'd0);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk_f);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk_s);
        @(negedge clk_f);
        chk(out_valid == 1'b0, "R6 reset state valid", 64'(out_valid), 64'd0);
        chk(collide_err == 1'b0, "R6 reset state error", 64'(collide_err), 64'd0);

        stream(40, 0);   // counting pattern, several ring wraps (R1)
        do_reset();
        stream(30, 1);   // walking one, restart latency (R6)
        do_reset();
        stream(20, 2);   // alternating all-ones / zeros

        // break the 2:1 relation: hold the slow clock two periods (R7)
        @(negedge clk_f);
        chk_en = 1'b0;
        hold   = 1'b1;
        repeat (4) @(posedge clk_f);
        @(negedge clk_f);
        hold = 1'b0;
        repeat (10) @(posedge clk_f);
        @(negedge clk_f);
        chk(collide_err == 1'b1, "R7 collision flagged", 64'(collide_err), 64'd1);
        repeat (20) @(posedge clk_f);
        @(negedge clk_f);
        chk(collide_err == 1'b1, "R7 flag sticky", 64'(collide_err), 64'd1);

        do_reset();
        stream(12, 3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule